// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block watches two interrupt mask bits of a processor, the ordinary mask bit and the non-maskable-request mask bit. It measures how many clock cycles each bit stays set. A free-running cycle counter provides the time base. The processor presents both bits together with a sample strobe once per instruction boundary. The block samples the bits only when the strobe is high.

A masked interval opens when the block samples a set bit and no interval is already open. At that point the current count is stored as the start. The interval closes when the block samples a clear bit. The duration is then the count at that moment minus the stored start.

For each bit the block keeps three statistics: the shortest, the longest and the most recent completed duration. It also reports a live duration while an interval is open. Until a first interval has completed, the reported shortest value falls back to the reported longest value. Debug and profiling logic reads these outputs directly.

Top module: `mask_span_monitor`

## Requirements
- R1: After reset the cycle counter reads 0. It then rises by one on every clock edge and stays at its all-ones value once it reaches it, with no wrap.
- R2: After reset, both channels report: no open interval, longest 0, last 0, live duration 0. The reported shortest value is also 0, because it falls back to the longest value.
- R3: A strobe with the mask bit at 1 and no open interval stores the current count as the start, and the open flag reads 1 from the next cycle. A strobe with the bit at 1 while an interval is open leaves the stored start unchanged.
- R4: A strobe with the mask bit at 0 while an interval is open computes the duration as count minus start. It stores that duration as the last value and clears the open flag from the next cycle.
- R5: On a close, the stored shortest value takes the duration only when the duration is strictly smaller. The stored shortest value starts at the all-ones sentinel.
- R6: On a close, the stored longest value takes the duration only when the duration is strictly larger. The reported longest value never decreases.
- R7: While the stored shortest value still holds the all-ones sentinel, the reported shortest value equals the reported longest value.
- R8: While an interval is open, the live duration output shows count minus start, and the reported longest value is the larger of the stored longest value and the live duration. While no interval is open, the live duration output reads 0.
- R9: The two channels use the same strobe and the same counter, and each channel's state depends only on its own mask bit.
- R10: Mask bit changes without a strobe have no effect on any statistic or on the open flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Instruction-boundary sample strobe |
| i_mask | input | 1 | Ordinary interrupt mask bit |
| x_mask | input | 1 | Non-maskable-request mask bit |
| cycle_now | output | CNT_W | Saturating cycle counter |
| i_open | output | 1 | Ordinary-mask interval in progress |
| i_min | output | CNT_W | Ordinary-mask shortest duration (reported) |
| i_max | output | CNT_W | Ordinary-mask longest duration (reported) |
| i_last | output | CNT_W | Ordinary-mask last completed duration |
| i_cur | output | CNT_W | Ordinary-mask live duration |
| x_open | output | 1 | Non-maskable-mask interval in progress |
| x_min | output | CNT_W | Non-maskable-mask shortest duration (reported) |
| x_max | output | CNT_W | Non-maskable-mask longest duration (reported) |
| x_last | output | CNT_W | Non-maskable-mask last completed duration |
| x_cur | output | CNT_W | Non-maskable-mask live duration |

## Verification
The bench builds the monitor with CNT_W set to 8. With that width the counter reaches its saturation point within a few hundred cycles, so the hold at all-ones and the zero-length intervals measured at saturation are both exercised. The 8-bit width also puts the shortest-value sentinel at 255. The bench sweeps interval lengths 1 to 12 on the ordinary channel. It pairs each length with three patterns on the other channel: opening with it, staying idle, and toggling without a strobe. Expected values come from cycle arithmetic in the bench.

// File: rtl/mspan_pkg.sv
package mspan_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_I   = 0;
    localparam int CH_X   = 1;
endpackage

// File: rtl/mspan_counter.sv
module mspan_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/mspan_channel.sv
module mspan_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         mask_bit,
    input  logic [W-1:0] now,
    output logic         open_o,
    output logic [W-1:0] min_o,
    output logic [W-1:0] max_o,
    output logic [W-1:0] last_o,
    output logic [W-1:0] cur_o
);
    localparam logic [W-1:0] SENTINEL = '1;

    typedef struct packed {
        logic         open;
        logic [W-1:0] start;
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic [W-1:0] last;
    } chan_st_t;

    chan_st_t     st_d, st_q;
    logic [W-1:0] span;
    logic [W-1:0] hi_rep;

    assign span = now - st_q.start;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (mask_bit && !st_q.open) begin
                st_d.start = now;
                st_d.open  = 1'b1;
            end else if (!mask_bit && st_q.open) begin
                if (span < st_q.lo) begin
                    st_d.lo = span;
                end
                if (span > st_q.hi) begin
                    st_d.hi = span;
                end
                st_d.last = span;
                st_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.open  <= 1'b0;
            st_q.start <= '0;
            st_q.lo    <= SENTINEL;
            st_q.hi    <= '0;
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hi_rep = st_q.hi;
        if (st_q.open && (span > st_q.hi)) begin
            hi_rep = span;
        end
    end

    assign open_o = st_q.open;
    assign cur_o  = st_q.open ? span : '0;
    assign max_o  = hi_rep;
    assign min_o  = (st_q.lo == SENTINEL) ? hi_rep : st_q.lo;
    assign last_o = st_q.last;
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor
    import mspan_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic             i_mask,
    input  logic             x_mask,
    output logic [CNT_W-1:0] cycle_now,
    output logic             i_open,
    output logic [CNT_W-1:0] i_min,
    output logic [CNT_W-1:0] i_max,
    output logic [CNT_W-1:0] i_last,
    output logic [CNT_W-1:0] i_cur,
    output logic             x_open,
    output logic [CNT_W-1:0] x_min,
    output logic [CNT_W-1:0] x_max,
    output logic [CNT_W-1:0] x_last,
    output logic [CNT_W-1:0] x_cur
);
    logic [CNT_W-1:0]  now;
    logic [NUM_CH-1:0] bits;
    logic [NUM_CH-1:0] opens;
    logic [CNT_W-1:0]  mins  [NUM_CH];
    logic [CNT_W-1:0]  maxs  [NUM_CH];
    logic [CNT_W-1:0]  lasts [NUM_CH];
    logic [CNT_W-1:0]  curs  [NUM_CH];

    mspan_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (now)
    );

    assign bits[CH_I] = i_mask;
    assign bits[CH_X] = x_mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mspan_channel #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb      (smp_stb),
            .mask_bit (bits[c]),
            .now      (now),
            .open_o   (opens[c]),
            .min_o    (mins[c]),
            .max_o    (maxs[c]),
            .last_o   (lasts[c]),
            .cur_o    (curs[c])
        );
    end

    assign cycle_now = now;
    assign i_open    = opens[CH_I];
    assign i_min     = mins[CH_I];
    assign i_max     = maxs[CH_I];
    assign i_last    = lasts[CH_I];
    assign i_cur     = curs[CH_I];
    assign x_open    = opens[CH_X];
    assign x_min     = mins[CH_X];
    assign x_max     = maxs[CH_X];
    assign x_last    = lasts[CH_X];
    assign x_cur     = curs[CH_X];
endmodule

// File: rtl/mspan_chk.sv
module mspan_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_stb,
    input logic         i_mask,
    input logic         x_mask,
    input logic [W-1:0] cycle_now,
    input logic         i_open,
    input logic [W-1:0] i_min,
    input logic [W-1:0] i_max,
    input logic [W-1:0] i_last,
    input logic         x_open,
    input logic [W-1:0] x_min,
    input logic [W-1:0] x_max,
    input logic [W-1:0] x_last
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FULL = '1;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_now != FULL) |=> ((cycle_now - $past(cycle_now)) == ONE));
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_now == FULL) |=> (cycle_now == FULL));
    // R3
    i_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && i_mask) |=> i_open);
    // R4
    x_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !x_mask && x_open) |=> !x_open);
    // R6
    i_max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_max >= $past(i_max));
    // R5
    x_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_min <= x_max);
    // R10
    i_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(i_last) && $stable(i_open)));
endmodule

bind mask_span_monitor mspan_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .i_mask    (i_mask),
    .x_mask    (x_mask),
    .cycle_now (cycle_now),
    .i_open    (i_open),
    .i_min     (i_min),
    .i_max     (i_max),
    .i_last    (i_last),
    .x_open    (x_open),
    .x_min     (x_min),
    .x_max     (x_max),
    .x_last    (x_last)
);

// File: tb/mask_span_monitor_test.sv
module mask_span_monitor_test;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int TOP    = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_stb = 1'b0;
    logic         i_mask = 1'b0;
    logic         x_mask = 1'b0;
    logic [W-1:0] cycle_now, i_min, i_max, i_last, i_cur, x_min, x_max, x_last, x_cur;
    logic         i_open, x_open;

    int n_chk = 0;
    int n_bad = 0;
    int e_cnt = 0;
    bit done  = 0;

    int m_open [2];
    int m_start[2];
    int m_min  [2];
    int m_max  [2];
    int m_last [2];

    always #(PERIOD/2) clk = ~clk;

    mask_span_monitor #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .i_mask(i_mask), .x_mask(x_mask), .cycle_now(cycle_now),
        .i_open(i_open), .i_min(i_min), .i_max(i_max), .i_last(i_last), .i_cur(i_cur),
        .x_open(x_open), .x_min(x_min), .x_max(x_max), .x_last(x_last), .x_cur(x_cur)
    );

    // Bench time base: edges since reset release, saturating (R1)
    always @(posedge clk) begin
        if (!rst_n) e_cnt <= 0;
        else if (e_cnt < TOP) e_cnt <= e_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_open[c] = 0; m_start[c] = 0; m_min[c] = TOP; m_max[c] = 0; m_last[c] = 0;
        end
    endtask

    task automatic chk_ch(input int c, input string ctx, input int op, input int mn,
                          input int mx, input int la, input int cu);
        int cur, hi, lo;
        cur = m_open[c] ? (e_cnt - m_start[c]) : 0;
        hi  = (m_open[c] && cur > m_max[c]) ? cur : m_max[c];
        lo  = (m_min[c] == TOP) ? hi : m_min[c];
        chk({ctx, " R3 open"}, op, m_open[c]);
        chk({ctx, " R5/R7 min"}, mn, lo);
        chk({ctx, " R6 max"}, mx, hi);
        chk({ctx, " R4 last"}, la, m_last[c]);
        chk({ctx, " R8 cur"}, cu, cur);
    endtask

    // Called at a negedge
    task automatic check_all(input string ctx);
        chk({ctx, " R1 cnt"}, int'(cycle_now), e_cnt);
        chk_ch(0, {ctx, " I"}, int'(i_open), int'(i_min), int'(i_max), int'(i_last), int'(i_cur));
        chk_ch(1, {ctx, " X R9"}, int'(x_open), int'(x_min), int'(x_max), int'(x_last), int'(x_cur));
    endtask

    task automatic model_strobe(input int c, input bit b);
        int d;
        if (b && m_open[c] == 0) begin
            m_start[c] = e_cnt; m_open[c] = 1;
        end else if (!b && m_open[c] == 1) begin
            d = e_cnt - m_start[c];
            if (d < m_min[c]) m_min[c] = d;
            if (d > m_max[c]) m_max[c] = d;
            m_last[c] = d; m_open[c] = 0;
        end
    endtask

    // At a negedge: one-cycle strobe, model updated with count seen at next edge
    task automatic strobe(input bit bi, input bit bx);
        smp_stb = 1'b1; i_mask = bi; x_mask = bx;
        model_strobe(0, bi);
        model_strobe(1, bx);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic idle(input int n, input bit wiggle);
        for (int k = 0; k < n; k++) begin
            if (wiggle) begin
                i_mask = ~i_mask; x_mask = ~x_mask;   // R10: no strobe, no effect
            end
            @(negedge clk);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R2 reset");
        idle(5, 0);
        check_all("R1 count");

        for (int len = 1; len <= 12; len++) begin
            for (int pat = 0; pat < 3; pat++) begin
                strobe(1'b1, pat == 0);
                check_all("R3 opened");
                idle(len / 2, pat == 2);
                strobe(1'b1, pat == 0);     // R3: reopen attempt keeps start
                idle(len - len / 2, pat == 2);
                check_all("R8 live");
                strobe(1'b0, 1'b0);
                check_all("R4 closed");
                idle(2, 1'b1);
                check_all("R10 quiet");
            end
        end

        // R5: shorter interval after longer ones
        strobe(1'b1, 1'b1);
        strobe(1'b0, 1'b0);
        check_all("R5 short");

        // R1: saturation, then zero-length intervals at the held count
        idle(TOP + 20, 0);
        check_all("R1 saturate");
        strobe(1'b1, 1'b1);
        check_all("R8 sat open");
        idle(3, 0);
        strobe(1'b0, 1'b0);
        check_all("R5 zero span");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule